// File: doc/BRIEF.md
# 10 Mb/s Manchester Transmitter with Jabber Lockout

This block is the transmit half of a 10 Mb/s twisted-pair port. It takes 4-bit nibbles from a MAC's media-independent transmit side, shifts each nibble out one bit at a time, and Manchester codes every bit into two half-bit symbols. The block runs on one clock whose period is half a bit time, which is 20 MHz for a 10 Mb/s line. The block pulses `nib_req` during the cycle in which it samples `txd`. This gives the MAC a nibble-rate strobe, so it can present the next nibble in time.

While no frame is being sent, a timer emits a short link pulse at a fixed interval. A second timer measures how long `tx_en` stays high without a break. If that time reaches a limit, the block enters a lockout state. In that state the line output is held low and `jabber` is raised. The block leaves the lockout only after `tx_en` has been low for an unbroken unjab period.

The controller has three states. ST_IDLE is the quiet line, where link pulses are sent. ST_SEND is active transmission. ST_JAB is the lockout. The transitions are:
- idle to send: `tx_en` is high and the jabber limit is not reached.
- send to send: at a nibble boundary `tx_en` is still high, so the next nibble is loaded.
- send to idle: at a nibble boundary `tx_en` is low.
- idle or send to jabber: the trip condition is met.
- jabber to idle: the unjab count completes.

All timings are parameters counted in half-bit cycles. The defaults are about 50 ms for the jabber limit, 500 ms for the unjab period, 16 ms for the link pulse period and 100 ns for the pulse width.

Top module: `tx10_jabber_tx`

## Requirements
- R1: During and right after reset the block is in ST_IDLE. In that state `mdi_bit`, `link_pulse` and `jabber` are 0, and `nib_req` equals `tx_en`.
- R2: Each data bit occupies two clock cycles. `mdi_bit` is the complement of the bit in the first cycle and the bit itself in the second cycle. Outside ST_SEND, `mdi_bit` is 0.
- R3: In ST_IDLE, `txd` is sampled on the first clock edge at which `tx_en` is high. While the frame continues, `txd` is sampled again every 8 cycles. `nib_req` is high exactly in the cycle before each sampling edge. Bits go out LSB first: `txd[0]` starts in the cycle after its sampling edge, then `txd[1]`, `txd[2]` and `txd[3]` follow.
- R4: If `tx_en` is low at a nibble-boundary edge, the frame ends at that edge. The block returns to ST_IDLE, `mdi_bit` stays 0 and `nib_req` is 0 in that boundary cycle.
- R5: In ST_IDLE, let j be the number of edges since idle was entered; the reset release counts as j = 0. `link_pulse` is 1 exactly when (j mod LP_PERIOD) >= LP_PERIOD - LP_WIDTH. It is 0 in every other state.
- R6: Outside ST_JAB, once `tx_en` has been high on JAB_CYC consecutive edges, the block enters ST_JAB at that edge, even in the middle of a bit. `jabber` is then 1 and `mdi_bit` is 0.
- R7: In ST_JAB, `tx_en` and `txd` have no effect on the outputs: `mdi_bit`, `link_pulse` and `nib_req` stay 0.
- R8: The block leaves ST_JAB for ST_IDLE at the UNJAB_CYC-th consecutive edge at which `tx_en` is low. A single high edge restarts that count. On exit `jabber` falls and the link pulse timer restarts from j = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Half-bit clock (20 MHz for 10 Mb/s) |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_en | input | 1 | Transmit enable from the MAC |
| txd | input | NIB_W | Transmit nibble from the MAC |
| nib_req | output | 1 | High in the cycle whose closing edge samples `txd` |
| mdi_bit | output | 1 | Manchester-coded line symbol |
| link_pulse | output | 1 | Idle link pulse |
| jabber | output | 1 | High while transmission is locked out |

## Verification
The bench samples at every falling edge and keeps a cycle index for each result: m counts edges since the first sampling edge, j counts edges since idle was entered, and l counts consecutive low edges in lockout. Line symbols for nibble n, bit b and half h are due at m = 8n + 2b + h. `nib_req` is checked 1 ns after each new nibble is driven. The jabber flag is due in the sample after edge m = JAB_CYC - 1, and release is due after edge l = UNJAB_CYC. Link pulse samples are compared with (j mod LP_PERIOD) >= LP_PERIOD - LP_WIDTH, using a small configuration in which all 16 nibble values, two pulse periods and an interrupted unjab run are swept.

// File: rtl/tx10_pkg.sv
package tx10_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SEND = 2'd1,
        ST_JAB  = 2'd2
    } tx_state_e;
endpackage

// File: rtl/tx10_serializer.sv
module tx10_serializer #(
    parameter int NIB_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             run,
    input  logic [NIB_W-1:0] nib_in,
    output logic             last_half,
    output logic             second_half,
    output logic             line_bit
);
    localparam int PH_N  = 2 * NIB_W;
    localparam int PH_W  = $clog2(PH_N);
    localparam int BIT_W = (NIB_W > 1) ? $clog2(NIB_W) : 1;
    localparam logic [PH_W-1:0] PH_LAST = PH_W'(PH_N - 1);

    logic [PH_W-1:0]  ph;
    logic [NIB_W-1:0] sh;
    logic [BIT_W-1:0] bidx;
    logic             cur;

    // half-bit phase counter and nibble holding register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph <= '0;
            sh <= '0;
        end else if (load) begin
            ph <= '0;
            sh <= nib_in;
        end else if (run) begin
            ph <= (ph == PH_LAST) ? '0 : ph + 1'b1;
        end else begin
            ph <= '0;
        end
    end

    always_comb begin
        bidx        = BIT_W'(ph >> 1);
        cur         = sh[bidx];
        second_half = ph[0];
        last_half   = run && (ph == PH_LAST);
        line_bit    = run && (ph[0] ? cur : ~cur);
    end

    // R3: held nibble only changes on a load
    p_nib_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !load) |=> $stable(sh));
endmodule

// File: rtl/tx10_jab_timer.sv
module tx10_jab_timer #(
    parameter int JAB_CYC   = 1_000_000,
    parameter int UNJAB_CYC = 10_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tx_en,
    input  logic in_jab,
    output logic trip,
    output logic release_jab
);
    localparam int ON_W  = $clog2(JAB_CYC + 1);
    localparam int OFF_W = $clog2(UNJAB_CYC + 1);
    localparam logic [ON_W-1:0]  ON_LAST  = ON_W'(JAB_CYC - 1);
    localparam logic [OFF_W-1:0] OFF_LAST = OFF_W'(UNJAB_CYC - 1);

    logic [ON_W-1:0]  on_cnt;
    logic [OFF_W-1:0] off_cnt;

    // consecutive high edges of tx_en outside lockout
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            on_cnt <= '0;
        end else if (in_jab || !tx_en) begin
            on_cnt <= '0;
        end else if (on_cnt != ON_LAST) begin
            on_cnt <= on_cnt + 1'b1;
        end
    end

    // consecutive low edges of tx_en inside lockout
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            off_cnt <= '0;
        end else if (!in_jab || tx_en) begin
            off_cnt <= '0;
        end else if (off_cnt != OFF_LAST) begin
            off_cnt <= off_cnt + 1'b1;
        end
    end

    always_comb begin
        trip        = !in_jab && tx_en && (on_cnt == ON_LAST);
        release_jab = in_jab && !tx_en && (off_cnt == OFF_LAST);
    end

    // R6: the run-length count never passes the limit
    p_on_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
        on_cnt <= ON_LAST);
    // R8: a high edge in lockout restarts the idle count
    p_unjab_restart_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_jab && tx_en) |=> (off_cnt == '0));
endmodule

// File: rtl/tx10_link_timer.sv
module tx10_link_timer #(
    parameter int LP_PERIOD = 320_000,
    parameter int LP_WIDTH  = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic active,
    output logic pulse
);
    localparam int CNT_W = $clog2(LP_PERIOD);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(LP_PERIOD - 1);
    localparam logic [CNT_W-1:0] CNT_ON   = CNT_W'(LP_PERIOD - LP_WIDTH);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n || !active) begin
            cnt <= '0;
        end else begin
            cnt <= (cnt == CNT_LAST) ? '0 : cnt + 1'b1;
        end
    end

    always_comb pulse = active && (cnt >= CNT_ON);

    // R5: a pulse that ends while idle has lasted the full width
    p_pulse_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (active && pulse && cnt == CNT_LAST) |=> (cnt == '0));
endmodule

// File: rtl/tx10_jabber_tx.sv
module tx10_jabber_tx
    import tx10_pkg::*;
#(
    parameter int NIB_W     = 4,
    parameter int JAB_CYC   = 1_000_000,
    parameter int UNJAB_CYC = 10_000_000,
    parameter int LP_PERIOD = 320_000,
    parameter int LP_WIDTH  = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tx_en,
    input  logic [NIB_W-1:0] txd,
    output logic             nib_req,
    output logic             mdi_bit,
    output logic             link_pulse,
    output logic             jabber
);
    tx_state_e st, st_nx;
    logic      load, run, last_half, second_half;
    logic      trip, release_jab, line_bit, lp_raw;

    tx10_serializer #(.NIB_W(NIB_W)) u_ser (
        .clk(clk), .rst_n(rst_n), .load(load), .run(run), .nib_in(txd),
        .last_half(last_half), .second_half(second_half), .line_bit(line_bit)
    );

    tx10_jab_timer #(.JAB_CYC(JAB_CYC), .UNJAB_CYC(UNJAB_CYC)) u_jab (
        .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .in_jab(st == ST_JAB),
        .trip(trip), .release_jab(release_jab)
    );

    tx10_link_timer #(.LP_PERIOD(LP_PERIOD), .LP_WIDTH(LP_WIDTH)) u_lp (
        .clk(clk), .rst_n(rst_n), .active(st == ST_IDLE), .pulse(lp_raw)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= st_nx;
    end

    // next-state logic
    always_comb begin
        st_nx = st;
        unique case (st)
            ST_IDLE: begin
                if (trip)       st_nx = ST_JAB;
                else if (tx_en) st_nx = ST_SEND;
            end
            ST_SEND: begin
                if (trip)                   st_nx = ST_JAB;
                else if (last_half && !tx_en) st_nx = ST_IDLE;
            end
            ST_JAB: begin
                if (release_jab) st_nx = ST_IDLE;
            end
            default: st_nx = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        run        = (st == ST_SEND);
        load       = !trip && tx_en &&
                     ((st == ST_IDLE) || (st == ST_SEND && last_half));
        nib_req    = load;
        mdi_bit    = line_bit;
        link_pulse = lp_raw;
        jabber     = (st == ST_JAB);
    end

    // R2: within a bit the second half is the inverse of the first
    p_manch_pair_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_SEND && !second_half && !trip) |=> (mdi_bit != $past(mdi_bit)));
    // R6: a trip always lands in lockout
    p_trip_enter_r6: assert property (@(posedge clk) disable iff (!rst_n)
        trip |=> jabber);
    // R7: lockout keeps the line, the pulses and the strobe quiet
    p_jab_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        jabber |-> (!mdi_bit && !link_pulse && !nib_req));
    // R8: lockout holds until the release condition
    p_jab_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (jabber && !release_jab) |=> jabber);
    // R5: no link pulse while a frame is on the line
    p_no_pulse_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_SEND) |-> !link_pulse);
    // R4: leaving transmission happens only at a nibble boundary or by trip
    p_end_boundary_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_SEND && !last_half && !trip) |=> (st == ST_SEND));
endmodule

// File: tb/sim_tx10_jabber_tx.sv
module sim_tx10_jabber_tx;
    localparam int NW = 4;
    localparam int JC = 40;
    localparam int UC = 20;
    localparam int LP = 16;
    localparam int LW = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          tx_en = 1'b0;
    logic [NW-1:0] txd = '0;
    logic          nib_req, mdi_bit, link_pulse, jabber;
    int            total = 0;
    int            bad = 0;
    bit            done = 1'b0;

    always #10 clk = ~clk;

    tx10_jabber_tx #(.NIB_W(NW), .JAB_CYC(JC), .UNJAB_CYC(UC),
                     .LP_PERIOD(LP), .LP_WIDTH(LW)) u0 (
        .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .txd(txd),
        .nib_req(nib_req), .mdi_bit(mdi_bit), .link_pulse(link_pulse),
        .jabber(jabber)
    );

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
        end
    endtask

    function automatic int lp_exp(input int j);
        return ((j % LP) >= (LP - LW)) ? 1 : 0;
    endfunction

    // idle stretch: first sample is j = j0
    task automatic idle_run(input int j0, input int n, input string req);
        for (int j = j0; j < j0 + n; j++) begin
            if (j > j0) @(negedge clk);
            chk({req, " link"}, int'(link_pulse), lp_exp(j));
            chk({req, " line"}, int'(mdi_bit), 0);
            chk({req, " jab"}, int'(jabber), 0);
        end
    endtask

    // R2 R3 R4: four-nibble frame, nibble 0 in the low bits
    task automatic send_frame(input logic [15:0] nibs);
        tx_en = 1'b1;
        txd   = nibs[3:0];
        #1 chk("R3 first req", int'(nib_req), 1);
        for (int n = 0; n < 4; n++) begin
            for (int h = 0; h < 8; h++) begin
                int b;
                int v;
                @(negedge clk);
                b = int'(nibs[4*n + h/2]);
                v = (h % 2 == 0) ? 1 - b : b;
                chk("R2 manchester", int'(mdi_bit), v);
                chk("R5 no pulse in frame", int'(link_pulse), 0);
                if (h == 3) chk("R3 mid-nibble req", int'(nib_req), 0);
                if (h == 7) begin
                    if (n < 3) txd = nibs[4*(n+1) +: 4];
                    else tx_en = 1'b0;
                    #1 chk((n < 3) ? "R3 next req" : "R4 end req", int'(nib_req),
                           (n < 3) ? 1 : 0);
                end
            end
        end
        @(negedge clk);
        idle_run(0, 20, "R4 R5 gap");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 reset line", int'(mdi_bit), 0);
        chk("R1 reset link", int'(link_pulse), 0);
        chk("R1 reset jab", int'(jabber), 0);
        rst_n = 1'b1;
        #1 chk("R1 req idle low", int'(nib_req), 0);
        idle_run(0, 1, "R1 release");
        @(negedge clk);
        idle_run(1, 40, "R5 idle");

        send_frame(16'h3210);
        send_frame(16'h7654);
        send_frame(16'hBA98);
        send_frame(16'hFEDC);
        send_frame(16'h5A0F);

        // R6 R7: unbroken tx_en beyond the limit
        tx_en = 1'b1;
        txd   = 4'h1;
        for (int m = 0; m <= 50; m++) begin
            int n;
            int b;
            n = m / 8;
            @(negedge clk);
            if (m < JC - 1) begin
                b = ((((n * 3) + 1) & 15) >> ((m % 8) / 2)) & 1;
                chk("R6 pre-trip line", int'(mdi_bit), (m % 2 == 0) ? 1 - b : b);
                chk("R6 pre-trip jab", int'(jabber), 0);
            end else begin
                chk("R6 jab set", int'(jabber), 1);
                chk("R7 line quiet", int'(mdi_bit), 0);
                chk("R7 link quiet", int'(link_pulse), 0);
            end
            if (m % 8 == 7) begin
                txd = NW'(((n + 1) * 3 + 1) & 15);
                #1;
                if (m >= JC - 1) chk("R7 req quiet", int'(nib_req), 0);
            end
        end

        // R8: interrupted unjab, then a full run
        tx_en = 1'b0;
        repeat (10) begin
            @(negedge clk);
            chk("R8 short idle", int'(jabber), 1);
        end
        tx_en = 1'b1;
        txd   = 4'hF;
        @(negedge clk);
        chk("R8 interrupted", int'(jabber), 1);
        chk("R7 line in jab", int'(mdi_bit), 0);
        tx_en = 1'b0;
        for (int l = 1; l <= UC; l++) begin
            @(negedge clk);
            chk("R8 unjab count", int'(jabber), (l < UC) ? 1 : 0);
        end
        idle_run(0, 20, "R8 R5 after unjab");
        send_frame(16'hC3A5);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule